// File: doc/BRIEF.md
# Configurable Vertical Sync Generator

This block drives the vertical sync output and the odd/even field indicator of a standard-definition interlaced video stream. An upstream timing unit supplies the current line number and two one-clock strobes marking the begin and the end of each horizontal sync pulse. The block takes one of those strobes as its start-of-line reference. It counts samples from that reference to find mid-line. From this it decides, line by line, when the field flips and when the vertical sync pin goes active or inactive.

Every option is a static input port and is meant to change only while reset is held. For each field and for each of the two VS edges (begin and end), a select bit places the edge either at the start-of-line reference or at mid-line. A further bit picks which horizontal sync strobe is the reference, and a polarity bit sets the active level of the pin. The line numbers of the VS edges and of the field changes are inputs as well. The block has no data stream, so it has no valid/ready handshake and no back-pressure. All of its pins are plain control and status signals.

Top module: `vsync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `vs_o` takes its inactive level (equal to `cfg_pol_low`) and `field_o` becomes 0.
- R2: In the odd field (`field_o` = 0), VS goes active on line `beg_line_odd`. With `cfg_beg_start_odd` = 0 this happens at mid-line, which is SAMPLES_PER_LINE/2 clocks after the reference strobe. With `cfg_beg_start_odd` = 1 it happens at the reference strobe.
- R3: In the even field (`field_o` = 1), VS goes active on line `beg_line_even`, placed by `cfg_beg_start_even` in the same way as in R2. This is independent of the odd-field setting.
- R4: In the odd field, VS goes inactive on line `end_line_odd`. It does so at mid-line when `cfg_end_start_odd` = 0 and at the reference strobe when it is 1.
- R5: In the even field, VS goes inactive on line `end_line_even`, placed by `cfg_end_start_even` in the same way as in R4.
- R6: With `cfg_ref_hsb` = 0, `hs_end` is the start-of-line reference. With `cfg_ref_hsb` = 1, `hs_begin` is the reference. The strobe that is not selected has no effect, and the line number is sampled from `line_cnt` at the reference strobe.
- R7: With `cfg_pol_low` = 0, `vs_o` is 1 when active. With `cfg_pol_low` = 1, `vs_o` is 0 when active.
- R8: At a reference strobe, `field_o` changes from 0 to 1 when `line_cnt` equals `fld_even_line`, and from 1 to 0 when it equals `fld_odd_line`. It changes at no other time.
- R9: A mid-line VS edge uses the field value that holds after that line's own field change.
- R10: `vs_o` and `field_o` change exactly one clock after the qualifying strobe or mid-line count, and at no other time.
- R11: If a begin and an end qualify at the same moment, the begin wins and VS becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_begin | input | 1 | One-clock strobe at the begin of horizontal sync |
| hs_end | input | 1 | One-clock strobe at the end of horizontal sync |
| line_cnt | input | LINE_W | Current line number |
| cfg_ref_hsb | input | 1 | 1: `hs_begin` is the start-of-line reference; 0: `hs_end` is |
| cfg_pol_low | input | 1 | 1: VS is active low |
| cfg_beg_start_odd | input | 1 | Odd-field VS begin at line start (1) or mid-line (0) |
| cfg_beg_start_even | input | 1 | Even-field VS begin at line start (1) or mid-line (0) |
| cfg_end_start_odd | input | 1 | Odd-field VS end at line start (1) or mid-line (0) |
| cfg_end_start_even | input | 1 | Even-field VS end at line start (1) or mid-line (0) |
| beg_line_odd | input | LINE_W | Line on which VS begins in the odd field |
| beg_line_even | input | LINE_W | Line on which VS begins in the even field |
| end_line_odd | input | LINE_W | Line on which VS ends in the odd field |
| end_line_even | input | LINE_W | Line on which VS ends in the even field |
| fld_even_line | input | LINE_W | Line on which the field changes from odd to even |
| fld_odd_line | input | LINE_W | Line on which the field changes from even to odd |
| vs_o | output | 1 | Vertical sync pin |
| field_o | output | 1 | Field indicator, 0 = odd, 1 = even |

## Verification
The hardest case to reach is the line on which the field flips and a VS edge is also due at mid-line. The mid-line decision then has to use the new field, but the select bits of the old field would give a different, earlier edge. The stimulus sets the even-field begin line equal to the odd-to-even change line, with a mid-line select. It also sets the same begin line for the odd field, with a start-of-line select, so that a wrong field choice shows up as VS rising about half a line early. A second hard case is a begin and an end landing on the same line and the same edge position, which the stimulus creates by giving both the same line number.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  typedef enum logic {FLD_ODD = 1'b0, FLD_EVEN = 1'b1} field_e;
  localparam int NUM_FIELDS = 2;
endpackage

// File: rtl/vsync_line_track.sv
// Picks the start-of-line reference strobe, counts samples from it and
// flags mid-line; keeps the line number seen at the reference (R6, R10).
module vsync_line_track #(
  parameter int SAMPLES_PER_LINE = 858,
  parameter int LINE_W           = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_begin,
  input  logic              hs_end,
  input  logic              ref_hsb,
  input  logic [LINE_W-1:0] line_cnt,
  output logic              start_evt,
  output logic              mid_evt,
  output logic [LINE_W-1:0] line_sel
);
  localparam int POS_W = $clog2(SAMPLES_PER_LINE + 1);
  localparam logic [POS_W-1:0] HALF_POS = POS_W'(SAMPLES_PER_LINE / 2);
  localparam logic [POS_W-1:0] SAT_POS  = POS_W'(SAMPLES_PER_LINE);
  localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

  logic [POS_W-1:0]  pos_q;
  logic              run_q;
  logic [LINE_W-1:0] line_q;

  assign start_evt = ref_hsb ? hs_begin : hs_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      run_q  <= 1'b0;
      line_q <= '0;
    end else if (start_evt) begin
      pos_q  <= ONE_POS;
      run_q  <= 1'b1;
      line_q <= line_cnt;
    end else if (run_q && (pos_q != SAT_POS)) begin
      pos_q  <= pos_q + ONE_POS;
    end
  end

  assign mid_evt  = run_q && !start_evt && (pos_q == HALF_POS);
  assign line_sel = start_evt ? line_cnt : line_q;
endmodule

// File: rtl/vsync_field_gen.sv
// Field state: flips only at a reference strobe on the configured lines (R8).
module vsync_field_gen
  import vsync_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic [LINE_W-1:0] line_sel,
  input  logic [LINE_W-1:0] fld_even_line,
  input  logic [LINE_W-1:0] fld_odd_line,
  output field_e            field_q,
  output field_e            field_eff
);
  always_comb begin
    field_eff = field_q;
    if (start_evt) begin
      if ((field_q == FLD_ODD) && (line_sel == fld_even_line))
        field_eff = FLD_EVEN;
      else if ((field_q == FLD_EVEN) && (line_sel == fld_odd_line))
        field_eff = FLD_ODD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) field_q <= FLD_ODD;
    else     field_q <= field_eff;
  end
endmodule

// File: rtl/vsync_edge_sel.sv
// Decides whether this moment is a VS begin or end for the field in effect
// (R2..R5, R9).
module vsync_edge_sel
  import vsync_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic                  start_evt,
  input  logic                  mid_evt,
  input  field_e                field,
  input  logic [LINE_W-1:0]     line_sel,
  input  logic [NUM_FIELDS-1:0] beg_start,
  input  logic [NUM_FIELDS-1:0] end_start,
  input  logic [LINE_W-1:0]     beg_line_odd,
  input  logic [LINE_W-1:0]     beg_line_even,
  input  logic [LINE_W-1:0]     end_line_odd,
  input  logic [LINE_W-1:0]     end_line_even,
  output logic                  set_evt,
  output logic                  clr_evt
);
  logic [LINE_W-1:0]     beg_line [NUM_FIELDS];
  logic [LINE_W-1:0]     end_line [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] beg_now;
  logic [NUM_FIELDS-1:0] end_now;
  logic                  fsel;

  assign beg_line[0] = beg_line_odd;
  assign beg_line[1] = beg_line_even;
  assign end_line[0] = end_line_odd;
  assign end_line[1] = end_line_even;

  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      logic beg_hit;
      logic end_hit;
      assign beg_hit    = (line_sel == beg_line[g]);
      assign end_hit    = (line_sel == end_line[g]);
      assign beg_now[g] = beg_hit && (beg_start[g] ? start_evt : mid_evt);
      assign end_now[g] = end_hit && (end_start[g] ? start_evt : mid_evt);
    end
  endgenerate

  assign fsel    = (field == FLD_EVEN);
  assign set_evt = beg_now[fsel];
  assign clr_evt = end_now[fsel];
endmodule

// File: rtl/vsync_gen.sv
// Top: vertical sync pin and field indicator, registered outputs (R1, R7,
// R10, R11).
module vsync_gen
  import vsync_pkg::*;
#(
  parameter int SAMPLES_PER_LINE = 858,
  parameter int LINE_W           = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_begin,
  input  logic              hs_end,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              cfg_ref_hsb,
  input  logic              cfg_pol_low,
  input  logic              cfg_beg_start_odd,
  input  logic              cfg_beg_start_even,
  input  logic              cfg_end_start_odd,
  input  logic              cfg_end_start_even,
  input  logic [LINE_W-1:0] beg_line_odd,
  input  logic [LINE_W-1:0] beg_line_even,
  input  logic [LINE_W-1:0] end_line_odd,
  input  logic [LINE_W-1:0] end_line_even,
  input  logic [LINE_W-1:0] fld_even_line,
  input  logic [LINE_W-1:0] fld_odd_line,
  output logic              vs_o,
  output logic              field_o
);
  logic              start_evt;
  logic              mid_evt;
  logic [LINE_W-1:0] line_sel;
  field_e            field_q;
  field_e            field_eff;
  logic              set_evt;
  logic              clr_evt;
  logic              vs_act_q;
  logic              vs_nxt;

  vsync_line_track #(
    .SAMPLES_PER_LINE(SAMPLES_PER_LINE),
    .LINE_W          (LINE_W)
  ) i_track (
    .clk      (clk),
    .rst      (rst),
    .hs_begin (hs_begin),
    .hs_end   (hs_end),
    .ref_hsb  (cfg_ref_hsb),
    .line_cnt (line_cnt),
    .start_evt(start_evt),
    .mid_evt  (mid_evt),
    .line_sel (line_sel)
  );

  vsync_field_gen #(.LINE_W(LINE_W)) i_field (
    .clk          (clk),
    .rst          (rst),
    .start_evt    (start_evt),
    .line_sel     (line_sel),
    .fld_even_line(fld_even_line),
    .fld_odd_line (fld_odd_line),
    .field_q      (field_q),
    .field_eff    (field_eff)
  );

  vsync_edge_sel #(.LINE_W(LINE_W)) i_edge (
    .start_evt    (start_evt),
    .mid_evt      (mid_evt),
    .field        (field_eff),
    .line_sel     (line_sel),
    .beg_start    ({cfg_beg_start_even, cfg_beg_start_odd}),
    .end_start    ({cfg_end_start_even, cfg_end_start_odd}),
    .beg_line_odd (beg_line_odd),
    .beg_line_even(beg_line_even),
    .end_line_odd (end_line_odd),
    .end_line_even(end_line_even),
    .set_evt      (set_evt),
    .clr_evt      (clr_evt)
  );

  // Begin has priority over end when both qualify together (R11).
  always_comb begin
    if (set_evt)      vs_nxt = 1'b1;
    else if (clr_evt) vs_nxt = 1'b0;
    else              vs_nxt = vs_act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_act_q <= 1'b0;
      vs_o     <= cfg_pol_low;
    end else begin
      vs_act_q <= vs_nxt;
      vs_o     <= vs_nxt ^ cfg_pol_low;
    end
  end

  assign field_o = (field_q == FLD_EVEN);
endmodule

// File: rtl/vsync_gen_chk.sv
module vsync_gen_chk (
  input logic clk,
  input logic rst,
  input logic hs_begin,
  input logic hs_end,
  input logic cfg_ref_hsb,
  input logic cfg_pol_low,
  input logic mid_evt,
  input logic set_evt,
  input logic clr_evt,
  input logic vs_o,
  input logic field_o
);
  logic ref_evt;
  logic rst_q;

  assign ref_evt = cfg_ref_hsb ? hs_begin : hs_end;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      AST_RESET_INACTIVE: assert ((vs_o == cfg_pol_low) && !field_o)
        else $error("reset level wrong"); // R1
    end
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ref_evt |=> $stable(field_o)); // R8

  AST_VS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ref_evt && !mid_evt) |=> $stable(vs_o)); // R10

  AST_MID_APART: assert property (@(posedge clk) disable iff (rst)
    ref_evt |-> !mid_evt); // R6

  AST_BEGIN_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> (vs_o != cfg_pol_low)); // R11

  AST_END_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !set_evt) |=> (vs_o == cfg_pol_low)); // R4
endmodule

bind vsync_gen vsync_gen_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .hs_begin   (hs_begin),
  .hs_end     (hs_end),
  .cfg_ref_hsb(cfg_ref_hsb),
  .cfg_pol_low(cfg_pol_low),
  .mid_evt    (mid_evt),
  .set_evt    (set_evt),
  .clr_evt    (clr_evt),
  .vs_o       (vs_o),
  .field_o    (field_o)
);

// File: tb/test_vsync_gen.sv
module test_vsync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SPL        = 32;
  localparam int HALF       = SPL / 2;
  localparam int HSE_OFF    = 4;
  localparam int LW         = 10;
  localparam int LINES      = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hs_begin = 1'b0;
  logic          hs_end = 1'b0;
  logic [LW-1:0] line_cnt = '0;
  logic          ref_hsb = 1'b0;
  logic          pol_low = 1'b0;
  logic          beg_st [2];
  logic          end_st [2];
  logic [LW-1:0] beg_ln [2];
  logic [LW-1:0] end_ln [2];
  logic [LW-1:0] tog_even;
  logic [LW-1:0] tog_odd;
  logic          vs_o;
  logic          field_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    m_vs;
  bit    m_fld;
  bit    q_vs [$];
  bit    q_fld [$];
  string q_req [$];
  string cur_req;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vsync_gen #(.SAMPLES_PER_LINE(SPL), .LINE_W(LW)) i_vsync_gen (
    .clk               (clk),
    .rst               (rst),
    .hs_begin          (hs_begin),
    .hs_end            (hs_end),
    .line_cnt          (line_cnt),
    .cfg_ref_hsb       (ref_hsb),
    .cfg_pol_low       (pol_low),
    .cfg_beg_start_odd (beg_st[0]),
    .cfg_beg_start_even(beg_st[1]),
    .cfg_end_start_odd (end_st[0]),
    .cfg_end_start_even(end_st[1]),
    .beg_line_odd      (beg_ln[0]),
    .beg_line_even     (beg_ln[1]),
    .end_line_odd      (end_ln[0]),
    .end_line_even     (end_ln[1]),
    .fld_even_line     (tog_even),
    .fld_odd_line      (tog_odd),
    .vs_o              (vs_o),
    .field_o           (field_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expectation for the cycle whose edge just passed.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_vs.size() != 0) begin
        bit    ev;
        bit    ef;
        string er;
        ev = q_vs.pop_front();
        ef = q_fld.pop_front();
        er = q_req.pop_front();
        check(er, "vs_o", vs_o, ev ^ pol_low);
        check(er, "field_o", field_o, ef);
      end
    end
  end

  // Driver: one line of SPL clocks; expectations from the requirements.
  task automatic drive_line(input int ln);
    int r;
    bit f;
    bit hb;
    bit he;
    bit v1;
    bit v2;
    r  = ref_hsb ? 0 : HSE_OFF;
    f  = m_fld;
    if (!m_fld && (ln == int'(tog_even)))     f = 1'b1;   // R8
    else if (m_fld && (ln == int'(tog_odd)))  f = 1'b0;
    hb = (ln == int'(beg_ln[f]));                         // R9: new field
    he = (ln == int'(end_ln[f]));
    v1 = m_vs;
    if (hb && beg_st[f])      v1 = 1'b1;                  // R11 begin first
    else if (he && end_st[f]) v1 = 1'b0;
    v2 = v1;
    if (hb && !beg_st[f])      v2 = 1'b1;
    else if (he && !end_st[f]) v2 = 1'b0;
    for (int c = 0; c < SPL; c++) begin
      @(negedge clk);
      hs_begin = (c == 0);
      hs_end   = (c == HSE_OFF);
      line_cnt = LW'(ln);
      // R10: effect visible one clock after the strobe / mid-line count.
      q_vs.push_back((c < r) ? m_vs : ((c < r + HALF) ? v1 : v2));
      q_fld.push_back((c < r) ? m_fld : f);
      q_req.push_back(cur_req);
    end
    m_vs  = v2;
    m_fld = f;
  endtask

  task automatic run_frames(input string req);
    cur_req = req;
    for (int fr = 0; fr < 2; fr++)
      for (int ln = 1; ln <= LINES; ln++)
        drive_line(ln);
    @(negedge clk);
    hs_begin = 1'b0;
    hs_end   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst      = 1'b1;
    hs_begin = 1'b0;
    hs_end   = 1'b0;
  endtask

  task automatic leave_reset();
    repeat (3) @(negedge clk);
    check("R1", "vs_o in reset", vs_o, pol_low);
    check("R1", "field_o in reset", field_o, 1'b0);
    rst   = 1'b0;
    m_vs  = 1'b0;
    m_fld = 1'b0;
  endtask

  task automatic cfg_base();
    beg_ln[0] = 2;  end_ln[0] = 4;
    beg_ln[1] = 7;  end_ln[1] = 9;
    tog_even  = 6;  tog_odd   = 1;
    beg_st[0] = 1'b0; beg_st[1] = 1'b0;
    end_st[0] = 1'b0; end_st[1] = 1'b0;
    ref_hsb   = 1'b0;
    pol_low   = 1'b0;
  endtask

  initial begin
    cfg_base();
    enter_reset();
    leave_reset();
    run_frames("R2 R3 R4 R5 mid-line defaults");

    enter_reset();
    cfg_base();
    beg_st[0] = 1'b1; end_st[1] = 1'b1; ref_hsb = 1'b1;
    leave_reset();
    run_frames("R3 R4 R6 mixed selects hs_begin ref");

    enter_reset();
    cfg_base();
    end_st[0] = 1'b1; beg_st[1] = 1'b1; pol_low = 1'b1;
    leave_reset();
    run_frames("R2 R5 R7 active low");

    enter_reset();
    cfg_base();
    beg_ln[0] = 6; beg_st[0] = 1'b1;
    beg_ln[1] = 6; beg_st[1] = 1'b0;
    leave_reset();
    run_frames("R9 R8 mid-line after field change");

    enter_reset();
    cfg_base();
    beg_ln[0] = 3; end_ln[0] = 3; beg_st[0] = 1'b1; end_st[0] = 1'b1;
    leave_reset();
    run_frames("R11 begin and end same moment");

    enter_reset();
    cfg_base();
    beg_st = '{1'b1, 1'b1}; end_st = '{1'b1, 1'b1};
    ref_hsb = 1'b1; pol_low = 1'b1;
    leave_reset();
    run_frames("R6 R7 R10 all at line start");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule